// File: doc/BRIEF.md
# NAND Page-Program Sequencer

This block is the host-side controller that writes one page into a NAND-style flash device. A request gives a row address and a start column. The data then arrives as a stream of items on a valid/ready handshake. A stream item is either a data byte or a column-jump item. A jump item carries a new column and splits the page into separate segments. The sequencer drives the command, address and data bytes onto an 8-bit bus, with one write or read strobe per clock. It then waits for the device to finish programming and ends with a one-cycle done pulse and a pass/fail flag.

During the load phase, a command byte is marked by the command-latch line and an address byte by the address-latch line. A data byte has neither line high. After the programming command, the sequencer issues the status command and reads status repeatedly. It stops when status bit 6 reports ready or when the ready/busy input is high. The pass/fail result is taken from bit 0 of that final status byte. A cycle counter bounds the wait, so a device that never becomes ready still produces a done pulse, with fail set.

Top module: `nand_prog_seq`

## Requirements
- R1: After a request is accepted, the write strobes carry, in order: command 80h with command-latch high, the column low byte and then the column high byte, the row bytes from least significant to most significant (each address byte with address-latch high), and then the data bytes with both latch lines low.
- R2: A stream item with `dat_jump` high is written as command 85h, followed by the two bytes of `dat_col` (low byte first) with address-latch high. Data bytes then continue from the next stream item.
- R3: The first data item that has `dat_last` high is the final data byte written. Command 10h follows it directly.
- R4: Directly after 10h, the sequencer writes command 70h. It then issues read strobes until a status read sees bit 6 high or `bus_rb` high. Exactly one read strobe sees that ready condition, and no write strobe occurs during the polling.
- R5: When polling ends because the device is ready, `fail` equals bit 0 of the final status byte read (0 means pass, 1 means fail).
- R6: At most MAX_BYTES data bytes are written per page. The MAX_BYTES-th data byte ends the data phase as if it carried `dat_last`, and `dat_ready` does not rise again for that operation.
- R7: If the device is still busy after TIMEOUT_CYC polling cycles, the operation ends with a done pulse and `fail` high.
- R8: `req_ready` is low from the cycle after a request is accepted until the cycle after the done pulse. `done` is high for exactly one cycle.
- R9: After reset, `req_ready` is high, and `dat_ready`, `done`, `bus_we` and `bus_re` are low.
- R10: A jump item does not count toward the MAX_BYTES limit and is accepted through the same handshake as a data byte. `dat_ready` is high only during the data phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Page-program request valid |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_row | input | ROW_W | Row (page) address |
| req_col | input | COL_W | Start column |
| dat_valid | input | 1 | Stream item valid |
| dat_ready | output | 1 | Stream item accepted this cycle when valid |
| dat_byte | input | 8 | Data byte of a data item |
| dat_last | input | 1 | Marks the final data item |
| dat_jump | input | 1 | Item is a column jump, not data |
| dat_col | input | COL_W | New column of a jump item |
| bus_cle | output | 1 | Command latch, qualifies a command byte |
| bus_ale | output | 1 | Address latch, qualifies an address byte |
| bus_we | output | 1 | Write strobe, one per clock |
| bus_re | output | 1 | Read strobe for a status read |
| bus_dq_out | output | 8 | Byte written to the device |
| bus_dq_in | input | 8 | Status byte read from the device |
| bus_rb | input | 1 | Device ready (1) / busy (0) |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Result, valid with done and held afterwards |

## Verification
The bench sweeps every data length from one byte up to the byte limit and above it, with and without a column jump at each position. Each run checks the complete logged strobe sequence. An off-by-one in the byte cap shows up as a ninth data byte, or as 10h arriving one byte early. A jump that was counted as data cuts a full page short. The completion is driven in turn by status bit 6 alone, by ready/busy alone, and by neither. A design that ignored one of these paths would time out and report a false fail, and a design that polled once too many would record two ready reads. A timeout run checks that a design without a bounded wait hangs, and that one returning the stale status bit reports a pass.

// File: rtl/nps_pkg.sv
package nps_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_CMD80, S_ADDR, S_DATA, S_CMD85, S_JADDR,
    S_CMD10, S_CMD70, S_POLL, S_SAMPLE, S_DONE
  } nps_state_e;

  typedef enum logic [2:0] {
    BUS_NONE, BUS_CMD, BUS_ADDR, BUS_DATA, BUS_READ
  } bus_kind_e;

  localparam logic [7:0] OP_LOAD  = 8'h80;
  localparam logic [7:0] OP_JUMP  = 8'h85;
  localparam logic [7:0] OP_START = 8'h10;
  localparam logic [7:0] OP_STAT  = 8'h70;

  localparam int RDY_BIT  = 6;
  localparam int FAIL_BIT = 0;

endpackage

// File: rtl/nps_addr_sel.sv
module nps_addr_sel #(
  parameter int NBYTES = 5,
  parameter int IW     = 3
) (
  input  logic [NBYTES*8-1:0] vec,
  input  logic [IW-1:0]       idx,
  output logic [7:0]          sel
);
  // byte lane picked by index, lane 0 = least significant
  always_comb begin
    sel = '0;
    for (int i = 0; i < NBYTES; i++) begin
      if (idx == IW'(i)) sel = vec[i*8 +: 8];
    end
  end
endmodule

// File: rtl/nps_timer.sv
module nps_timer #(
  parameter int LIMIT = 100000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expired
);
  localparam int W = $clog2(LIMIT + 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (cnt != W'(LIMIT)) cnt <= cnt + 1'b1;
  end

  assign expired = (cnt == W'(LIMIT));

  // R7: expiry only follows a run of polling cycles
  assert_expire_needs_run_R7: assert property (@(posedge clk) disable iff (rst)
    expired |-> $past(run));
endmodule

// File: rtl/nps_bus_drv.sv
module nps_bus_drv
  import nps_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  bus_kind_e  kind,
  input  logic [7:0] data,
  output logic       cle,
  output logic       ale,
  output logic       we,
  output logic       re,
  output logic [7:0] dq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cle <= 1'b0;
      ale <= 1'b0;
      we  <= 1'b0;
      re  <= 1'b0;
      dq  <= '0;
    end else begin
      cle <= (kind == BUS_CMD);
      ale <= (kind == BUS_ADDR);
      we  <= (kind == BUS_CMD) || (kind == BUS_ADDR) || (kind == BUS_DATA);
      re  <= (kind == BUS_READ);
      dq  <= (kind == BUS_NONE || kind == BUS_READ) ? 8'h00 : data;
    end
  end
endmodule

// File: rtl/nand_prog_seq.sv
module nand_prog_seq
  import nps_pkg::*;
#(
  parameter int MAX_BYTES   = 2112,
  parameter int TIMEOUT_CYC = 100000,
  parameter int COL_W       = 16,
  parameter int ROW_W       = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [ROW_W-1:0] req_row,
  input  logic [COL_W-1:0] req_col,
  input  logic             dat_valid,
  output logic             dat_ready,
  input  logic [7:0]       dat_byte,
  input  logic             dat_last,
  input  logic             dat_jump,
  input  logic [COL_W-1:0] dat_col,
  output logic             bus_cle,
  output logic             bus_ale,
  output logic             bus_we,
  output logic             bus_re,
  output logic [7:0]       bus_dq_out,
  input  logic [7:0]       bus_dq_in,
  input  logic             bus_rb,
  output logic             done,
  output logic             fail
);
  localparam int COL_BYTES  = COL_W / 8;
  localparam int ROW_BYTES  = ROW_W / 8;
  localparam int ADDR_BYTES = COL_BYTES + ROW_BYTES;
  localparam int IDX_W      = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
  localparam int CNT_W      = $clog2(MAX_BYTES + 1);

  nps_state_e       state, nxt;
  logic [IDX_W-1:0] idx;
  logic [CNT_W-1:0] cnt;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  bus_kind_e        op_kind;
  logic [7:0]       op_byte;
  logic [7:0]       addr_byte;
  logic             tmr_run, tmr_exp;
  logic             finish, finish_fail;
  logic             dev_ready;
  logic             unused_status;

  assign unused_status = ^{bus_dq_in[7], bus_dq_in[5:1]};
  assign dev_ready     = bus_dq_in[RDY_BIT] | bus_rb;

  nps_addr_sel #(.NBYTES(ADDR_BYTES), .IW(IDX_W)) u_addr (
    .vec ({row_q, col_q}),
    .idx (idx),
    .sel (addr_byte)
  );

  assign tmr_run = (state == S_POLL) || (state == S_SAMPLE);

  nps_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .run     (tmr_run),
    .expired (tmr_exp)
  );

  always_comb begin
    nxt         = state;
    op_kind     = BUS_NONE;
    op_byte     = '0;
    finish      = 1'b0;
    finish_fail = 1'b0;
    case (state)
      S_IDLE:  if (req_valid) nxt = S_CMD80;
      S_CMD80: begin
        op_kind = BUS_CMD;
        op_byte = OP_LOAD;
        nxt     = S_ADDR;
      end
      S_ADDR: begin
        op_kind = BUS_ADDR;
        op_byte = addr_byte;
        if (idx == IDX_W'(ADDR_BYTES - 1)) nxt = S_DATA;
      end
      S_DATA: begin
        if (dat_valid) begin
          if (dat_jump) begin
            nxt = S_CMD85;
          end else begin
            op_kind = BUS_DATA;
            op_byte = dat_byte;
            if (dat_last || cnt == CNT_W'(MAX_BYTES - 1)) nxt = S_CMD10;
          end
        end
      end
      S_CMD85: begin
        op_kind = BUS_CMD;
        op_byte = OP_JUMP;
        nxt     = S_JADDR;
      end
      S_JADDR: begin
        op_kind = BUS_ADDR;
        op_byte = addr_byte;
        if (idx == IDX_W'(COL_BYTES - 1)) nxt = S_DATA;
      end
      S_CMD10: begin
        op_kind = BUS_CMD;
        op_byte = OP_START;
        nxt     = S_CMD70;
      end
      S_CMD70: begin
        op_kind = BUS_CMD;
        op_byte = OP_STAT;
        nxt     = S_POLL;
      end
      S_POLL: begin
        op_kind = BUS_READ;
        nxt     = S_SAMPLE;
      end
      S_SAMPLE: begin
        if (dev_ready) begin
          finish      = 1'b1;
          finish_fail = bus_dq_in[FAIL_BIT];
          nxt         = S_DONE;
        end else if (tmr_exp) begin
          finish      = 1'b1;
          finish_fail = 1'b1;
          nxt         = S_DONE;
        end else begin
          nxt = S_POLL;
        end
      end
      S_DONE:  nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      idx   <= '0;
      cnt   <= '0;
      row_q <= '0;
      col_q <= '0;
      done  <= 1'b0;
      fail  <= 1'b0;
    end else begin
      state <= nxt;
      if ((state == S_ADDR || state == S_JADDR) && nxt == state) idx <= idx + 1'b1;
      else idx <= '0;
      if (state == S_IDLE && req_valid) begin
        row_q <= req_row;
        col_q <= req_col;
        cnt   <= '0;
      end
      if (state == S_DATA && dat_valid) begin
        if (dat_jump) col_q <= dat_col;
        else          cnt   <= cnt + 1'b1;
      end
      done <= finish;
      if (finish) fail <= finish_fail;
    end
  end

  assign req_ready = (state == S_IDLE);
  assign dat_ready = (state == S_DATA);

  nps_bus_drv u_bus (
    .clk  (clk),
    .rst  (rst),
    .kind (op_kind),
    .data (op_byte),
    .cle  (bus_cle),
    .ale  (bus_ale),
    .we   (bus_we),
    .re   (bus_re),
    .dq   (bus_dq_out)
  );

  // R3: the final data byte is followed by the program-start command
  assert_start_after_last_R3: assert property (@(posedge clk) disable iff (rst)
    (state == S_DATA && dat_valid && !dat_jump && dat_last)
      |=> ##1 (bus_we && bus_cle && bus_dq_out == OP_START));

  // R4: while a status byte is being sampled, no write strobe is driven
  assert_poll_read_only_R4: assert property (@(posedge clk) disable iff (rst)
    (state == S_SAMPLE) |-> (bus_re && !bus_we));

  // R6: the data count never passes the page limit
  assert_byte_limit_R6: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(MAX_BYTES));

  // R7: an expired wait on a busy device reports failure
  assert_timeout_fail_R7: assert property (@(posedge clk) disable iff (rst)
    (state == S_SAMPLE && tmr_exp && !dev_ready) |=> (done && fail));

  // R8: done is a single-cycle pulse
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8: an accepted request closes the request port
  assert_busy_refuse_R8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);
endmodule

// File: tb/nand_prog_seq_test.sv
module nand_prog_seq_test;
  localparam int MAXB = 8;
  localparam int TMO  = 40;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_ready;
  logic [23:0] req_row;
  logic [15:0] req_col;
  logic        dat_valid, dat_ready, dat_last, dat_jump;
  logic [7:0]  dat_byte;
  logic [15:0] dat_col;
  logic        bus_cle, bus_ale, bus_we, bus_re, bus_rb;
  logic [7:0]  bus_dq_out, bus_dq_in;
  logic        done, fail;

  always #10 clk = ~clk;

  nand_prog_seq #(.MAX_BYTES(MAXB), .TIMEOUT_CYC(TMO)) uut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_row(req_row), .req_col(req_col),
    .dat_valid(dat_valid), .dat_ready(dat_ready), .dat_byte(dat_byte),
    .dat_last(dat_last), .dat_jump(dat_jump), .dat_col(dat_col),
    .bus_cle(bus_cle), .bus_ale(bus_ale), .bus_we(bus_we), .bus_re(bus_re),
    .bus_dq_out(bus_dq_out), .bus_dq_in(bus_dq_in), .bus_rb(bus_rb),
    .done(done), .fail(fail)
  );

  int tests = 0;
  int failed = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // write log and read counters, free running
  logic [9:0] wlog [2048];
  int wn = 0;
  int t10 = 0;
  int rd_n = 0;
  int rd_ok = 0;
  always @(posedge clk) begin
    if (bus_we && wn < 2048) begin
      wlog[wn] <= {bus_cle, bus_ale, bus_dq_out};
      wn <= wn + 1;
      if (bus_cle && bus_dq_out == 8'h10) t10 <= cyc;
    end
    if (bus_re) begin
      rd_n <= rd_n + 1;
      if (bus_dq_in[6] || bus_rb) rd_ok <= rd_ok + 1;
    end
  end

  // device model: mode 0 both signals, 1 status bit only, 2 ready/busy only
  int busy_cfg = 0;
  int busy_left = 0;
  int mode = 0;
  bit fail_cfg = 1'b0;
  logic dev_rdy;
  always @(posedge clk) begin
    if (bus_we && bus_cle && bus_dq_out == 8'h10) busy_left <= busy_cfg;
    else if (busy_left > 0) busy_left <= busy_left - 1;
  end
  assign dev_rdy   = (busy_left == 0);
  assign bus_rb    = (mode == 1) ? 1'b0 : dev_rdy;
  assign bus_dq_in = {1'b0, (mode == 2) ? 1'b0 : dev_rdy, 5'b0, fail_cfg};

  logic hs_d, hs_r;
  always @(posedge clk) begin
    hs_d <= dat_valid && dat_ready;
    hs_r <= req_valid && req_ready;
  end

  bit         it_j [16];
  bit         it_l [16];
  logic [7:0] it_b [16];
  logic [15:0] it_c [16];
  int ni;
  logic [9:0] exp_log [64];
  int en;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    tests++;
    if (!ok) begin
      failed++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic run_op(input logic [15:0] col, input logic [23:0] row,
                        input int nb, input int jpos, input logic [15:0] jcol,
                        input int busy, input bit fb, input int md,
                        input bit tmo, input string req);
    int sent, idx, wbase, rbase, okbase, tdone, fl;
    bit stayed_low, mism;
    int bad_i;
    // stream items
    ni = 0;
    for (int i = 0; i < nb; i++) begin
      if (i == jpos) begin
        it_j[ni] = 1'b1; it_l[ni] = 1'b0; it_b[ni] = 8'h00; it_c[ni] = jcol; ni++;
      end
      it_j[ni] = 1'b0; it_l[ni] = (i == nb - 1);
      it_b[ni] = (col[7:0] ^ 8'h5A) + 8'(i * 7); it_c[ni] = 16'h0; ni++;
    end
    // expected write sequence: {cle, ale, byte}
    en = 0;
    exp_log[en++] = {2'b10, 8'h80};
    exp_log[en++] = {2'b01, col[7:0]};
    exp_log[en++] = {2'b01, col[15:8]};
    exp_log[en++] = {2'b01, row[7:0]};
    exp_log[en++] = {2'b01, row[15:8]};
    exp_log[en++] = {2'b01, row[23:16]};
    sent = 0;
    for (int i = 0; i < ni; i++) begin
      if (it_j[i]) begin
        exp_log[en++] = {2'b10, 8'h85};
        exp_log[en++] = {2'b01, it_c[i][7:0]};
        exp_log[en++] = {2'b01, it_c[i][15:8]};
      end else begin
        exp_log[en++] = {2'b00, it_b[i]};
        sent++;
        if (it_l[i] || sent == MAXB) break;
      end
    end
    exp_log[en++] = {2'b10, 8'h10};
    exp_log[en++] = {2'b10, 8'h70};

    busy_cfg = busy; fail_cfg = fb; mode = md;
    @(negedge clk);
    wbase = wn; rbase = rd_n; okbase = rd_ok;
    req_col = col; req_row = row; req_valid = 1'b1;
    forever begin
      @(negedge clk);
      if (hs_r) break;
    end
    req_valid = 1'b0;
    idx = 0; stayed_low = 1'b1;
    dat_valid = (ni > 0);
    dat_jump = it_j[0]; dat_last = it_l[0]; dat_byte = it_b[0]; dat_col = it_c[0];
    forever begin
      @(negedge clk);
      if (hs_d) idx++;
      if (req_ready) stayed_low = 1'b0;
      if (done) break;
      dat_valid = (idx < ni);
      if (idx < ni) begin
        dat_jump = it_j[idx]; dat_last = it_l[idx]; dat_byte = it_b[idx]; dat_col = it_c[idx];
      end
    end
    tdone = cyc; fl = int'(fail);
    dat_valid = 1'b0;

    // R1, R2, R3, R6, R10: complete strobe sequence
    mism = (wn - wbase != en);
    bad_i = -1;
    for (int i = 0; i < en && !mism; i++) begin
      if (wlog[wbase + i] != exp_log[i]) begin mism = 1'b1; bad_i = i; end
    end
    if (bad_i >= 0)
      check(1'b0, req, "write entry", int'(wlog[wbase + bad_i]), int'(exp_log[bad_i]));
    else
      check(!mism, req, "write count", wn - wbase, en);

    // R8: request port closed for the whole operation
    check(stayed_low, "R8", "req_ready low during op", 0, 1);
    if (tmo) begin
      check(fl == 1, "R7", "timeout fail flag", fl, 1);
      check(tdone - t10 >= TMO, "R7", "timeout wait length", tdone - t10, TMO);
    end else begin
      check(fl == int'(fb), "R5", "fail flag", fl, int'(fb));
      check(rd_ok - okbase == 1, "R4", "ready status reads", rd_ok - okbase, 1);
      check(tdone - t10 >= busy, "R4", "waited through busy", tdone - t10, busy);
      check(rd_n - rbase >= 1, "R4", "status reads issued", rd_n - rbase, 1);
    end
    @(negedge clk);
    check(!done, "R8", "done single cycle", int'(done), 0);
    check(req_ready, "R8", "req_ready back after done", int'(req_ready), 1);
    // R6: after a capped page no further item is taken
    check(!dat_ready, "R6", "dat_ready low after op", int'(dat_ready), 0);
  endtask

  task automatic main_flow();
    rst = 1'b1;
    req_valid = 1'b0; req_row = '0; req_col = '0;
    dat_valid = 1'b0; dat_byte = '0; dat_last = 1'b0; dat_jump = 1'b0; dat_col = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9: reset state
    check(req_ready, "R9", "req_ready after reset", int'(req_ready), 1);
    check(!dat_ready, "R9", "dat_ready after reset", int'(dat_ready), 0);
    check(!done, "R9", "done after reset", int'(done), 0);
    check(!bus_we && !bus_re, "R9", "no strobes after reset", int'({bus_we, bus_re}), 0);

    // R1 R3 R5 R4: every length up to the limit, each completion path
    for (int nb = 1; nb <= MAXB; nb++) begin
      for (int md = 0; md < 3; md++) begin
        run_op(16'h0100 + 16'(nb * 3 + md), 24'h0A0B00 + 24'(nb * 17 + md),
               nb, -1, 16'h0, 3 + nb + md, bit'((nb + md) % 2), md, 1'b0, "R1");
      end
    end
    // R2 R10: a column jump at every position of a six-byte page
    for (int jp = 0; jp < 6; jp++) begin
      run_op(16'h0040, 24'h123456, 6, jp, 16'h0700 + 16'(jp * 5), 5, bit'(jp % 2),
             jp % 3, 1'b0, "R2");
    end
    // R10: a jump does not consume the byte allowance
    run_op(16'h0002, 24'h00FF01, MAXB, 4, 16'h0321, 4, 1'b0, 0, 1'b0, "R10");
    // R6: stream longer than the limit is cut at the limit
    run_op(16'h07FF, 24'h800001, MAXB + 3, -1, 16'h0, 6, 1'b1, 0, 1'b0, "R6");
    run_op(16'h0010, 24'h010203, MAXB + 3, 3, 16'h0ABC, 2, 1'b0, 1, 1'b0, "R6");
    // R7: device never becomes ready within the limit
    run_op(16'h0020, 24'h000001, 3, -1, 16'h0, 1000, 1'b0, 0, 1'b1, "R3");
    // recovery after a timeout
    run_op(16'h0030, 24'h000002, 2, -1, 16'h0, 4, 1'b1, 2, 1'b0, "R5");
  endtask

  initial begin
    fork
      main_flow();
      begin
        repeat (200000) @(posedge clk);
        tests++;
        failed++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end
endmodule